// File: doc/BRIEF.md
# Serial Multiplexed ADC Host Controller

This block is the host side of a link to an external 10-bit successive-approximation converter that has an eight-way input multiplexer and a three-wire serial port. A client posts a request that names a channel (3 bits) and asks for right- or left-justified output. The controller then frames one serial exchange. It drops the active-low select, sends a 4-bit command, and runs a serial clock that it derives from the system clock. At the same time it shifts in the result the converter sends back. When the frame closes, the controller returns a 10-bit sample together with a one-cycle valid pulse.

The converter is pipelined. Each exchange sends the command for the next conversion and reads back the result of the conversion the previous command started. The number of clock periods in an exchange depends on the format of that earlier conversion: 10 periods when it was left-justified, and 16 periods when it was right-justified, because six zeros come ahead of the data in that case. The controller keeps the previous justification flag to size each frame. The first frame after reset carries a result that has no meaning, so the controller reports no valid pulse for it. When the busy wait is enabled, the controller waits after each frame for the converter's busy line to be seen high and then low before it takes the next request.

Top module: `sadc_host`

## Requirements
- R1: During and after reset, with no request taken, adcSelN is 1, adcClk is 0, rspValid is 0 and reqReady is 1.
- R2: After a request is taken, adcCmd presents the command MSB-first: channel bit 2, channel bit 1, channel bit 0, then the justification flag (1 = right). From the fifth clock period on it presents 0. adcCmd changes only in cycles where adcClk falls, so it is stable across every rising edge.
- R3: adcSelN falls in the cycle after the request is taken. It stays low for SETUP_CYC cycles with adcClk low before the first rising edge. It stays low until the last high phase of adcClk ends, and adcClk is never high while adcSelN is high.
- R4: Inside a frame, adcClk is high for CLK_DIV cycles and then low for CLK_DIV cycles, and it starts with the high phase after setup. Between frames it rests low.
- R5: A frame has 16 rising edges of adcClk when the previously taken request was right-justified. It has 10 when that request was left-justified, and also 10 for the first request after reset.
- R6: adcData is sampled at each rising edge of adcClk. The returned sample is the last 10 bits taken, with the earliest of these as the MSB, so the leading zeros of a right-justified frame are dropped.
- R7: rspValid is a one-cycle pulse in the first cycle that adcSelN is high again. rspData then holds the conversion result that the previous request started.
- R8: The first frame after any reset produces no rspValid pulse.
- R9: With WAIT_BUSY set, reqReady stays 0 after a frame until adcBusy has been seen high and then low through a two-stage synchronizer. reqReady returns no sooner than 2 and no later than 4 cycles after adcBusy falls.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, taken when reqReady is high |
| reqChan | input | 3 | Channel for the conversion to start |
| reqRight | input | 1 | 1 = right-justified, 0 = left-justified |
| reqReady | output | 1 | Controller idle and able to take a request |
| rspValid | output | 1 | One-cycle pulse marking a returned result |
| rspData | output | 10 | Result of the previous conversion |
| adcSelN | output | 1 | Active-low converter select |
| adcClk | output | 1 | Serial clock to the converter |
| adcCmd | output | 1 | Serial command to the converter |
| adcData | input | 1 | Serial result from the converter |
| adcBusy | input | 1 | Converter busy line, asynchronous |

## Verification
The bench builds the block with CLK_DIV = 2, SETUP_CYC = 3 and the busy wait enabled. With these values a 16-period frame fits in about 70 cycles, so mixed sequences of justification changes, extreme codes (all ones, all zeros, alternating bits) and a reset in mid-run are cheap to cover. The short divider keeps the half-period boundaries and the setup window close together, so an off-by-one in any counter shifts the waveform that the per-cycle model compares. The converter model holds a right-justified result at power-up, which exercises the first frame of 10 periods against a 16-bit shift register.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_HIGH   = 3'd2,
    ST_LOW    = 3'd3,
    ST_WAITHI = 3'd4,
    ST_WAITLO = 3'd5
  } sadcState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture new command
    logic sample;  // serial clock rises: take adcData
    logic shift;   // serial clock falls: advance command
    logic finish;  // frame ends: publish result
    logic keep;    // result is meaningful (not first after reset)
  } sadcStrobe_t;

endpackage

// File: rtl/sadc_datapath.sv
module sadc_datapath
  import sadc_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sadcStrobe_t       strb,
  input  logic [CHAN_W-1:0] reqChan,
  input  logic              reqRight,
  input  logic              adcData,
  output logic              adcCmd,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);
  localparam int CMD_W = CHAN_W + 1;

  logic [CMD_W-1:0]  cmdQ;
  logic [DATA_W-1:0] capQ;

  // command shifter: MSB goes out first, zeros follow
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cmdQ <= '0;
    else if (strb.load)  cmdQ <= {reqChan, reqRight};
    else if (strb.shift) cmdQ <= {cmdQ[CMD_W-2:0], 1'b0};
  end
  assign adcCmd = cmdQ[CMD_W-1];

  // capture keeps only the newest DATA_W bits (drops leading pad)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           capQ <= '0;
    else if (strb.sample) capQ <= {capQ[DATA_W-2:0], adcData};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.finish & strb.keep;
      if (strb.finish) rspData <= capQ;
    end
  end

  // R7: a result is a single-cycle pulse
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> !rspValid);

endmodule

// File: rtl/sadc_control.sv
module sadc_control
  import sadc_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int SETUP_CYC = 2,
  parameter bit WAIT_BUSY = 1'b1,
  parameter int LEFT_LEN  = 10,
  parameter int RIGHT_LEN = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        reqRight,
  input  logic        adcBusy,
  output logic        reqReady,
  output logic        adcSelN,
  output logic        adcClk,
  output sadcStrobe_t strb
);
  localparam int MAXC   = (CLK_DIV > SETUP_CYC) ? CLK_DIV : SETUP_CYC;
  localparam int DIV_W  = $clog2(MAXC + 1);
  localparam int CNT_W  = $clog2(RIGHT_LEN + 1);
  localparam logic [DIV_W-1:0] DIV_LAST   = DIV_W'(CLK_DIV - 1);
  localparam logic [DIV_W-1:0] SETUP_LAST = DIV_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LEFT_LAST  = CNT_W'(LEFT_LEN - 1);
  localparam logic [CNT_W-1:0] RIGHT_LAST = CNT_W'(RIGHT_LEN - 1);

  sadcState_t       state, nxt;
  logic [DIV_W-1:0] divCnt;
  logic [CNT_W-1:0] bitCnt;
  logic             lenRight, pendRight, firstDone;
  logic             busySync;
  logic [CNT_W-1:0] lastIdx;

  // busy input comes from another clock domain
  generate
    if (WAIT_BUSY) begin : g_busy
      logic busyMeta, busyQ;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          busyMeta <= 1'b0;
          busyQ    <= 1'b0;
        end else begin
          busyMeta <= adcBusy;
          busyQ    <= busyMeta;
        end
      end
      assign busySync = busyQ;
    end else begin : g_nobusy
      assign busySync = 1'b0;
    end
  endgenerate

  assign lastIdx = lenRight ? RIGHT_LAST : LEFT_LAST;

  always_comb begin
    nxt  = state;
    strb = '0;
    unique case (state)
      ST_IDLE:   if (reqValid) begin
                   strb.load = 1'b1;
                   nxt       = ST_SETUP;
                 end
      ST_SETUP:  if (divCnt == SETUP_LAST) begin
                   strb.sample = 1'b1;
                   nxt         = ST_HIGH;
                 end
      ST_HIGH:   if (divCnt == DIV_LAST) begin
                   if (bitCnt == lastIdx) begin
                     strb.finish = 1'b1;
                     nxt         = WAIT_BUSY ? ST_WAITHI : ST_IDLE;
                   end else begin
                     strb.shift = 1'b1;
                     nxt        = ST_LOW;
                   end
                 end
      ST_LOW:    if (divCnt == DIV_LAST) begin
                   strb.sample = 1'b1;
                   nxt         = ST_HIGH;
                 end
      ST_WAITHI: if (busySync)  nxt = ST_WAITLO;
      ST_WAITLO: if (!busySync) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
    strb.keep = firstDone;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      divCnt    <= '0;
      bitCnt    <= '0;
      lenRight  <= 1'b0;
      pendRight <= 1'b0;
      firstDone <= 1'b0;
      adcSelN   <= 1'b1;
      adcClk    <= 1'b0;
    end else begin
      state   <= nxt;
      divCnt  <= (nxt != state) ? '0 : divCnt + 1'b1;
      adcSelN <= !(nxt == ST_SETUP || nxt == ST_HIGH || nxt == ST_LOW);
      adcClk  <= (nxt == ST_HIGH);
      if (strb.load) begin
        bitCnt    <= '0;
        lenRight  <= pendRight;   // frame length follows the previous format
        pendRight <= reqRight;
      end else if (strb.shift) begin
        bitCnt <= bitCnt + 1'b1;
      end
      if (strb.finish) firstDone <= 1'b1;
    end
  end

  assign reqReady = (state == ST_IDLE);

  // checker: count rising edges of the serial clock per frame
  logic             clkPrev;
  logic [CNT_W-1:0] riseSeen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkPrev  <= 1'b0;
      riseSeen <= '0;
    end else begin
      clkPrev <= adcClk;
      if (adcSelN)                riseSeen <= '0;
      else if (adcClk && !clkPrev) riseSeen <= riseSeen + 1'b1;
    end
  end

  // R5: frame holds exactly the short or the long count of rising edges
  p_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adcSelN) |-> (riseSeen == CNT_W'(LEFT_LEN) || riseSeen == CNT_W'(RIGHT_LEN)));
  // R3: the serial clock only runs inside a frame
  p_clk_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adcClk |-> !adcSelN);
  // R3: select falls with the clock at rest
  p_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adcSelN) |-> !adcClk);
  // R9: a request is only offered between frames
  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> (adcSelN && !adcClk));

endmodule

// File: rtl/sadc_host.sv
module sadc_host
  import sadc_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int SETUP_CYC = 2,
  parameter bit WAIT_BUSY = 1'b1,
  parameter int DATA_W    = 10,
  parameter int CHAN_W    = 3,
  parameter int RIGHT_PAD = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [CHAN_W-1:0] reqChan,
  input  logic              reqRight,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              adcSelN,
  output logic              adcClk,
  output logic              adcCmd,
  input  logic              adcData,
  input  logic              adcBusy
);
  localparam int LEFT_LEN  = DATA_W;
  localparam int RIGHT_LEN = DATA_W + RIGHT_PAD;

  sadcStrobe_t strb;

  sadc_control #(
    .CLK_DIV(CLK_DIV), .SETUP_CYC(SETUP_CYC), .WAIT_BUSY(WAIT_BUSY),
    .LEFT_LEN(LEFT_LEN), .RIGHT_LEN(RIGHT_LEN)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqRight(reqRight),
    .adcBusy(adcBusy), .reqReady(reqReady), .adcSelN(adcSelN),
    .adcClk(adcClk), .strb(strb)
  );

  sadc_datapath #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) i_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .reqChan(reqChan),
    .reqRight(reqRight), .adcData(adcData), .adcCmd(adcCmd),
    .rspValid(rspValid), .rspData(rspData)
  );

  // R2: command bit is steady across each rising edge of the serial clock
  p_di_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adcClk) |-> $stable(adcCmd));

endmodule

// File: tb/test_sadc_host.sv
`timescale 1ns/1ps
module test_sadc_host;
  localparam int DIV   = 2;
  localparam int SETUP = 3;
  localparam int CONV  = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reqValid = 1'b0;
  logic [2:0] reqChan = '0;
  logic       reqRight = 1'b0;
  logic       reqReady, rspValid, adcSelN, adcClk, adcCmd;
  logic [9:0] rspData;
  logic       adcData = 1'b0;
  logic       adcBusy = 1'b0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sadc_host #(.CLK_DIV(DIV), .SETUP_CYC(SETUP), .WAIT_BUSY(1'b1)) i_sadc_host (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqChan(reqChan),
    .reqRight(reqRight), .reqReady(reqReady), .rspValid(rspValid),
    .rspData(rspData), .adcSelN(adcSelN), .adcClk(adcClk), .adcCmd(adcCmd),
    .adcData(adcData), .adcBusy(adcBusy)
  );

  // ---------------- behavioural converter model ----------------
  logic [9:0]  ain [8];
  logic [15:0] outSh;
  logic [3:0]  inSh = '0;
  int          inCnt = 0;
  logic [9:0]  storedVal = 10'h2AA;
  logic        storedRight = 1'b1;
  int          busyLeft = 0;

  always @(negedge adcSelN) begin
    outSh   = storedRight ? {6'b0, storedVal} : {storedVal, 6'b0};
    adcData = outSh[15];
    inCnt   = 0;
  end
  always @(negedge adcClk) if (!adcSelN) begin
    outSh   = outSh << 1;
    adcData = outSh[15];
  end
  always @(posedge adcClk) if (!adcSelN) begin
    if (inCnt < 4) inSh = {inSh[2:0], adcCmd};
    inCnt++;
  end
  always @(posedge adcSelN) if (inCnt >= 4) begin
    storedVal   = ain[inSh[3:1]];
    storedRight = inSh[0];
    inCnt       = 0;
    busyLeft    = CONV;
    adcBusy    <= 1'b1;
  end
  always @(posedge clk) if (busyLeft > 0) begin
    busyLeft--;
    if (busyLeft == 0) adcBusy <= 1'b0;
  end

  // ---------------- checking ----------------
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // reference state of the controller, reset along with it
  bit         expFirst = 1'b1;
  bit         expPrevRight = 1'b0;
  logic [9:0] expPrevVal = '0;

  function automatic logic cmdBit(input logic [3:0] c, input int k);
    return (k < 4) ? c[3-k] : 1'b0;
  endfunction

  task automatic pins(input logic s, input logic c, input logic d, input string req);
    chk(adcSelN == s, req, adcSelN, s);
    chk(adcClk == c, req, adcClk, c);
    if (!s) chk(adcCmd == d, "R2 command bit", adcCmd, d);
  endtask

  task automatic doReq(input logic [2:0] ch, input logic rt);
    logic [3:0] cmd;
    int n, cnt;
    cmd = {ch, rt};
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqChan = ch; reqRight = rt;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    n = expPrevRight ? 16 : 10;  // R5
    for (int s = 0; s < SETUP; s++) begin
      pins(1'b0, 1'b0, cmd[3], "R3 setup window");
      @(negedge clk);
    end
    for (int k = 0; k < n; k++) begin
      for (int d = 0; d < DIV; d++) begin
        pins(1'b0, 1'b1, cmdBit(cmd, k), "R4 high phase");
        @(negedge clk);
      end
      if (k < n - 1) for (int d = 0; d < DIV; d++) begin
        pins(1'b0, 1'b0, cmdBit(cmd, k + 1), "R4 low phase");
        @(negedge clk);
      end
    end
    chk(adcSelN == 1'b1, "R5 frame end", adcSelN, 1);
    chk(adcClk == 1'b0, "R4 clock rests low", adcClk, 0);
    if (expFirst) chk(rspValid == 1'b0, "R8 first result hidden", rspValid, 0);
    else begin
      chk(rspValid == 1'b1, "R7 valid pulse", rspValid, 1);
      chk(rspData == expPrevVal, "R6 R7 result", rspData, expPrevVal);
    end
    @(negedge clk);
    chk(rspValid == 1'b0, "R7 pulse width", rspValid, 0);
    chk(reqReady == 1'b0, "R9 busy wait", reqReady, 0);
    expFirst     = 1'b0;
    expPrevVal   = ain[ch];
    expPrevRight = rt;
    while (adcBusy) begin
      chk(reqReady == 1'b0, "R9 ready held", reqReady, 0);
      pins(1'b1, 1'b0, 1'b0, "R4 idle between frames");
      @(negedge clk);
    end
    cnt = 0;
    while (!reqReady && cnt < 8) begin
      cnt++;
      @(negedge clk);
    end
    chk(cnt >= 2 && cnt <= 4, "R9 ready after busy", cnt, 3);
  endtask

  initial begin
    ain[0] = 10'h3FF; ain[1] = 10'h000; ain[2] = 10'h155; ain[3] = 10'h2AA;
    ain[4] = 10'h001; ain[5] = 10'h200; ain[6] = 10'h0F0; ain[7] = 10'h30C;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk(adcSelN == 1'b1, "R1 select in reset", adcSelN, 1);
    chk(adcClk == 1'b0, "R1 clock in reset", adcClk, 0);
    chk(rspValid == 1'b0, "R1 valid in reset", rspValid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready after reset", reqReady, 1);
    chk(adcSelN == 1'b1 && adcClk == 1'b0, "R1 idle pins", {adcSelN, adcClk}, 2);

    doReq(3'd3, 1'b0);  // first: hidden (R8), short frame
    doReq(3'd5, 1'b1);  // returns ch3 left-justified
    doReq(3'd0, 1'b1);  // long frame, returns ch5 right-justified
    doReq(3'd7, 1'b0);  // long frame, returns ch0 (all ones)
    doReq(3'd1, 1'b0);  // short frame, returns ch7
    doReq(3'd2, 1'b1);  // returns ch1 (all zeros)
    doReq(3'd4, 1'b0);  // long frame, returns ch2
    doReq(3'd6, 1'b1);  // returns ch4
    doReq(3'd1, 1'b1);  // long frame, returns ch6

    // R8 R5: reset in mid-run clears the history
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(adcSelN == 1'b1 && rspValid == 1'b0, "R1 second reset", {adcSelN, rspValid}, 2);
    rst_n = 1'b1;
    expFirst = 1'b1; expPrevRight = 1'b0;
    doReq(3'd0, 1'b0);  // short frame, no valid
    doReq(3'd3, 1'b0);  // returns ch0

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule